// File: doc/BRIEF.md
# Serial Register-Bank Slave Port

This block lets an external controller configure a chip over a four-wire serial link. It holds a bank of 128 eight-bit configuration registers. The controller reaches them through frames framed by an active-low select. The serial clock, select and input data are brought into the core clock domain by synchronizers. Input bits are taken on rising serial-clock edges, and output bits change on falling ones. Every byte travels most significant bit first.

Each frame opens with a device byte. Its upper seven bits must match a fixed chip identity, and its lowest bit chooses write or read. A write frame then carries a pointer byte, followed by any number of data bytes that land in consecutive registers. A write frame may also stop right after the pointer byte, which only moves the pointer. A read frame has no pointer byte. It streams registers out starting at the pointer left by the earlier frame. The pointer advances after every complete data byte and wraps around the bank.

The rest of the chip sees the register contents through a combinational read port.

Top module: `spi_regbank_port`

## Requirements
- R1: The upper seven bits of the first byte of a frame must equal binary 0010000. On any other value, the rest of the frame writes no register, moves no pointer and never enables the output.
- R2: Bit 0 of the first byte selects the direction: 0 for a write frame and 1 for a read frame. Input data during a read frame changes no register.
- R3: In a write frame, bits 6..0 of the second byte load the pointer, and bit 7 of that byte is ignored. Each following complete byte is stored in the register the pointer selects.
- R4: Input is sampled on rising serial-clock edges and `spi_miso` changes only after falling edges. It holds steady while the serial clock is high. Bytes move MSB first.
- R5: `spi_miso_oe` stays 0 and `spi_miso` stays high-impedance during a whole write frame, during the device byte of any frame, and whenever select is high.
- R6: A write frame that ends right after the pointer byte changes no register. A following read frame starts at that pointer.
- R7: In a read frame, the first falling serial-clock edge after the device byte enables the output and presents the MSB of the register at the pointer.
- R8: The pointer advances by one after each complete data byte in both directions, and it wraps from 127 to 0.
- R9: Frames are recognised only after a high-to-low transition of select that follows reset release. Traffic with select already low at reset release is ignored.
- R10: Raising select ends the frame at any bit and keeps the pointer. A data byte cut short by select is discarded.
- R11: After reset, all registers read 0, the pointer is 0 and the output is disabled. `cfg_rdata` shows the register addressed by `cfg_raddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out, high-impedance when not driven |
| spi_miso_oe | output | 1 | High while `spi_miso` is driven |
| cfg_raddr | input | 7 | Register index for the internal read port |
| cfg_rdata | output | 8 | Contents of the register at `cfg_raddr` |

## Verification
A wrong phase or bit count shows up within one byte. Either a register changes where none should, visible at once on `cfg_rdata`, or `spi_miso_oe` rises during a write or a device byte. A pointer that is off by one or fails to wrap stays hidden until the next read frame, which then returns a neighbouring register from its first falling edge. The sweeps therefore always follow a write or an abort with a full bank comparison and a read-back.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

  // Frame phases of the serial slave
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,  // deselected, waiting for select to fall
    PH_DEV   = 3'd1,  // receiving chip identity and direction
    PH_PTR   = 3'd2,  // write frame: receiving pointer byte
    PH_WDATA = 3'd3,  // write frame: receiving data bytes
    PH_RDATA = 3'd4,  // read frame: shifting register bytes out
    PH_SKIP  = 3'd5   // identity mismatch: ignore until deselect
  } phase_t;

endpackage

// File: rtl/spi_in_sync.sv
// Brings N asynchronous inputs into the core clock domain and flags
// their edges. Chains reset to 0 so that a select held low across
// reset never produces a falling edge.
module spi_in_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    logic              prev_q;

    assign sh_d = {sh_q[STAGES-2:0], din[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= sh_d;
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign lvl[g]  = sh_q[STAGES-1];
    assign rise[g] = sh_q[STAGES-1] & ~prev_q;
    assign fall[g] = ~sh_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/spi_cfg_bank.sv
// Flop-based configuration bank: one write port, two read ports.
module spi_cfg_bank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] row_en;

  // Write decode: one enable per row
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    assign row_en[r] = we && (waddr == AW'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (row_en[i]) mem_q[i] <= wdata;
      end
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame sequencer: bit counting, identity check, pointer, shifters.
module spi_frame_ctrl
  import spi_regbank_pkg::*;
#(
  parameter int              AW      = 7,
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-2:0] CHIP_ID = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_lvl,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     ptr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso_bit,
  output logic              miso_oe,
  output logic              in_read
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_t              phase_q, phase_d;
  logic [CNT_W-1:0]    bit_q, bit_d;
  logic [DATA_W-2:0]   shin_q, shin_d;
  logic [DATA_W-1:0]   shout_q, shout_d;
  logic [AW-1:0]       ptr_q, ptr_d;
  logic                oe_q, oe_d;
  logic [DATA_W-1:0]   byte_w;
  logic                byte_done;
  logic                wr_d;

  assign byte_w    = {shin_q, mosi_lvl};
  assign byte_done = (bit_q == LAST_BIT);

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    shin_d  = shin_q;
    shout_d = shout_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    wr_d    = 1'b0;

    if (cs_lvl) begin
      // deselected: abort frame, keep pointer
      phase_d = PH_IDLE;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (cs_fall) begin
        phase_d = PH_DEV;
        bit_d   = '0;
      end
    end else if (sclk_rise) begin
      shin_d = byte_w[DATA_W-2:0];
      bit_d  = byte_done ? '0 : bit_q + 1'b1;
      if (byte_done) begin
        unique case (phase_q)
          PH_DEV: begin
            if (byte_w[DATA_W-1:1] != CHIP_ID) phase_d = PH_SKIP;
            else if (byte_w[0])                 phase_d = PH_RDATA;
            else                                phase_d = PH_PTR;
          end
          PH_PTR: begin
            ptr_d   = byte_w[AW-1:0];
            phase_d = PH_WDATA;
          end
          PH_WDATA: begin
            wr_d  = 1'b1;
            ptr_d = ptr_q + 1'b1;
          end
          PH_RDATA: ptr_d = ptr_q + 1'b1;
          default: ;
        endcase
      end
    end else if (sclk_fall && (phase_q == PH_RDATA)) begin
      if (bit_q == '0) begin
        shout_d = rd_data;
        oe_d    = 1'b1;
      end else begin
        shout_d = {shout_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shin_q  <= shin_d;
      shout_q <= shout_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
    end
  end

  assign ptr      = ptr_q;
  assign wr_en    = wr_d;
  assign wr_data  = byte_w;
  assign miso_bit = shout_q[DATA_W-1];
  assign miso_oe  = oe_q;
  assign in_read  = (phase_q == PH_RDATA);

endmodule

// File: rtl/spi_regbank_port.sv
module spi_regbank_port #(
  parameter int                REG_AW      = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] CHIP_ID     = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [REG_AW-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata
);

  localparam int NSIG = 3;
  localparam int I_CS = 0;
  localparam int I_CK = 1;
  localparam int I_DI = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n_s = rst_sh_q[1];

  logic [NSIG-1:0] pin_in, pin_lvl, pin_rise, pin_fall;
  assign pin_in = {spi_mosi, spi_sclk, spi_cs_n};

  spi_in_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (pin_in),
    .lvl   (pin_lvl),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  logic              cs_lvl;
  logic              wr_en;
  logic [REG_AW-1:0] ptr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] ptr_rdata;
  logic              miso_bit;
  logic              miso_oe;
  logic              in_read;

  assign cs_lvl = pin_lvl[I_CS];

  spi_frame_ctrl #(.AW(REG_AW), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_lvl    (cs_lvl),
    .cs_fall   (pin_fall[I_CS]),
    .sclk_rise (pin_rise[I_CK]),
    .sclk_fall (pin_fall[I_CK]),
    .mosi_lvl  (pin_lvl[I_DI]),
    .rd_data   (ptr_rdata),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .miso_bit  (miso_bit),
    .miso_oe   (miso_oe),
    .in_read   (in_read)
  );

  spi_cfg_bank #(.AW(REG_AW), .DW(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (wr_en),
    .waddr   (ptr),
    .wdata   (wr_data),
    .raddr_a (ptr),
    .rdata_a (ptr_rdata),
    .raddr_b (cfg_raddr),
    .rdata_b (cfg_rdata)
  );

  assign spi_miso_oe = miso_oe;
  assign spi_miso    = miso_oe ? miso_bit : 1'bz;

  // Pin-to-pin unused-bit sink: rise of select and edges of data are not needed
  logic unused_edges;
  assign unused_edges = ^{pin_rise[I_CS], pin_rise[I_DI], pin_fall[I_DI], pin_lvl[I_CK]};

endmodule

// File: rtl/spi_regbank_port_chk.sv
module spi_regbank_port_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_lvl,
  input logic          wr_en,
  input logic [AW-1:0] ptr,
  input logic          miso_oe,
  input logic          in_read
);

  // R5: output released once select is seen high
  a_r5_hiz_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !miso_oe);

  // R5: output only driven inside a read frame data phase
  a_r5_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> in_read);

  // R8: each stored byte advances the pointer by one, wrapping
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 1'b1));

  // R10: pointer kept while deselected
  a_r10_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(ptr));

  // R3: one store per received byte
  a_r3_single_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

bind spi_regbank_port spi_regbank_port_chk #(.AW(REG_AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_lvl  (cs_lvl),
  .wr_en   (wr_en),
  .ptr     (ptr),
  .miso_oe (spi_miso_oe),
  .in_read (in_read)
);

// File: tb/spi_regbank_port_tb.sv
module spi_regbank_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HB         = 8;      // core clocks per serial half period
  localparam logic [6:0] CHIP = 7'b0010000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso, spi_miso_oe;
  logic [6:0] cfg_raddr;
  logic [7:0] cfg_rdata;

  int tests = 0;
  int fails = 0;
  int hiz_bad = 0;
  int z_bad = 0;
  int hold_bad = 0;
  bit hiz_expect = 1'b0;

  logic [7:0] exp_mem [128];
  logic [6:0] exp_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regbank_port u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
  );

  // R5 monitor: enable low where required, pin floating whenever disabled
  always @(negedge clk) begin
    if (hiz_expect && spi_miso_oe) hiz_bad++;
    if (!spi_miso_oe && spi_miso !== 1'bz) z_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((k * 37 + seed * 11 + 5) & 255);
  endfunction

  // Shift nb bits of tx MSB first; rx collects the bit seen before each rise
  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    logic s0;
    rx = 'x;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = tx[i];
      wclk(HB);
      s0 = spi_miso;
      rx[i] = s0;
      spi_sclk = 1'b1;
      wclk(HB);
      if (spi_miso !== s0) hold_bad++;   // R4: steady while clock high
      spi_sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    wclk(HB);
  endtask

  task automatic cs_high();
    wclk(HB);
    spi_cs_n = 1'b1;
    wclk(2 * HB);
    hiz_expect = 1'b0;
  endtask

  task automatic check_bank(input string req);
    int bad = 0;
    int idx = 0;
    logic [7:0] act = '0;
    for (int i = 0; i < 128; i++) begin
      cfg_raddr = 7'(i);
      #1;
      if (cfg_rdata !== exp_mem[i] && bad == 0) begin
        idx = i;
        act = cfg_rdata;
      end
      if (cfg_rdata !== exp_mem[i]) bad++;
    end
    chk(bad == 0, req, int'(act), int'(exp_mem[idx]));
  endtask

  task automatic do_write(input logic [7:0] ptr_byte, input int n, input int seed);
    logic [7:0] rx;
    cs_low();
    hiz_expect = 1'b1;
    spi_byte({CHIP, 1'b0}, rx);
    spi_byte(ptr_byte, rx);
    exp_ptr = ptr_byte[6:0];
    for (int k = 0; k < n; k++) begin
      spi_byte(pat(seed, k), rx);
      exp_mem[exp_ptr] = pat(seed, k);
      exp_ptr = exp_ptr + 1'b1;
    end
    cs_high();
  endtask

  task automatic do_read(input int n, input string req_first, input string req_rest);
    logic [7:0] rx;
    cs_low();
    hiz_expect = 1'b1;
    spi_byte({CHIP, 1'b1}, rx);
    hiz_expect = 1'b0;
    wclk(HB / 2);
    // R7: enabled with the MSB after the first falling edge
    chk(spi_miso_oe === 1'b1 && spi_miso === exp_mem[exp_ptr][7], "R7",
        int'({spi_miso_oe, spi_miso}), int'({1'b1, exp_mem[exp_ptr][7]}));
    for (int k = 0; k < n; k++) begin
      spi_byte(8'hFF, rx);     // R2: input traffic during read is ignored
      chk(rx === exp_mem[exp_ptr], (k == 0) ? req_first : req_rest,
          int'(rx), int'(exp_mem[exp_ptr]));
      exp_ptr = exp_ptr + 1'b1;
    end
    cs_high();
    chk(spi_miso_oe === 1'b0, "R5", int'(spi_miso_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    exp_ptr    = '0;
    rst_n      = 1'b0;
    spi_cs_n   = 1'b0;          // held low through reset for R9
    spi_sclk   = 1'b0;
    spi_mosi   = 1'b0;
    cfg_raddr  = '0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);

    // R11: reset state
    chk(spi_miso_oe === 1'b0 && spi_miso === 1'bz, "R11", int'(spi_miso_oe), 0);
    check_bank("R11");

    // R9: a write clocked with no select fall after reset is ignored
    spi_byte({CHIP, 1'b0}, rx);
    spi_byte(8'h03, rx);
    spi_byte(8'hA5, rx);
    cs_high();
    check_bank("R9");

    // R3/R8: fill the whole bank in one frame, pointer wraps to 0
    do_write(8'h00, 128, 1);
    check_bank("R3");
    // R2/R8: read it all back plus one wrapped byte
    do_read(129, "R4", "R8");
    check_bank("R2");

    // R6/R3: pointer-only frame with bit 7 set selects register 5
    cs_low();
    hiz_expect = 1'b1;
    spi_byte({CHIP, 1'b0}, rx);
    spi_byte(8'h85, rx);
    cs_high();
    exp_ptr = 7'd5;
    check_bank("R6");
    do_read(2, "R6", "R8");

    // R8: write across the top of the bank
    do_write(8'h7F, 3, 2);
    check_bank("R8");
    do_read(1, "R8", "R8");

    // R10: one full byte then a 5-bit fragment cut by select
    cs_low();
    hiz_expect = 1'b1;
    spi_byte({CHIP, 1'b0}, rx);
    spi_byte(8'd20, rx);
    spi_byte(8'h5A, rx);
    exp_mem[20] = 8'h5A;
    spi_bits(8'hC3, 5, rx);
    cs_high();
    exp_ptr = 7'd21;
    check_bank("R10");
    do_read(1, "R10", "R10");

    // R1: every other identity, both directions, must be ignored
    for (int a = 0; a < 128; a++) begin
      if (7'(a) != CHIP) begin
        cs_low();
        hiz_expect = 1'b1;
        spi_byte({7'(a), 1'(a)}, rx);
        spi_byte(8'h3C, rx);
        spi_byte(8'hC3, rx);
        cs_high();
      end
    end
    check_bank("R1");
    do_read(1, "R1", "R1");

    chk(hiz_bad == 0, "R5", hiz_bad, 0);
    chk(z_bad == 0, "R5", z_bad, 0);
    chk(hold_bad == 0, "R4", hold_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule